// File: doc/BRIEF.md
# PCI Target Address and Command Decoder

This block watches the address phase of a 32-bit PCI bus and decides whether the local device is the target of the new transaction. It recognises a small set of bus commands. For each one it checks the matching selection rule. Configuration cycles need the device-select input and a type-0 address with function zero. I/O and memory cycles need an address that falls inside the window programmed into the I/O or memory base register. On a hit it emits a one-clock strobe to the backend. With the strobe it gives the command class, the configuration DWORD index and the offset of the access inside its window.

The block also holds the small configuration header that the decoding depends on. That header has a command word carrying the two space-enable bits, the two base registers, fixed identity and class words, and an interrupt control/status word for the backend. Configuration writes land in the data phase that the external handshake logic marks with `xfer`, and each byte is gated by its byte enable. Configuration read data for the selected DWORD is presented on `cfg_rdata`. During I/O and memory write data phases the active byte lanes are passed to the backend.

Top module: `pci_tgt_decode`

## Requirements
- R1: A hit is possible only for the bus command codes 0010 (I/O read), 0011 (I/O write), 0110 (memory read), 0111 (memory write), 1010 (configuration read) and 1011 (configuration write). Every other code never hits. `cmd_class` reports 1, 2, 3, 4, 5 and 6 for these six commands in that order, and 0 after a miss.
- R2: A configuration command hits only when `idsel` is high, AD[1:0] is 00 and AD[10:8] is 000. AD[31:11] have no effect. `cfg_index` is AD[7:2].
- R3: An I/O command hits when AD[31:8] equals bits 31:8 of the I/O base register (offset 10h, a 256-byte window). `tgt_offset` is AD[7:0], and the byte address is not checked against the byte enables.
- R4: A memory command hits when AD[31:22] equals bits 31:22 of the memory base register (offset 14h, a 4 MB window). `tgt_offset` is AD[21:0].
- R5: I/O decoding needs bit 0 and memory decoding needs bit 1 of the command word at offset 04h. Both bits are 0 after reset.
- R6: Writing all ones to a base register makes it read back its size mask. That gives FFFFFF01h for the I/O register and FFC00000h for the memory register. Bit 0 of the I/O register always reads 1, and the memory register's low 22 bits read 0.
- R7: Offset 00h reads the identity parameter and offset 08h reads the class parameter. Every configuration DWORD that is not implemented reads zero.
- R8: A configuration write changes only the bytes whose enable is active. C/BE[n] low enables byte n.
- R9: `wr_be` equals the inverted C/BE during an `xfer` of a selected I/O or memory write, and is 0000 at all other times.
- R10: At offset 48h, bit 0 is a writable interrupt enable (reset 0) and bit 8 reads the `bk_irq` input. `irq_out` is high exactly when both are high.
- R11: `hit` is high for exactly the one clock that follows the edge where `frame_n` is first sampled low. `cmd_class`, `cfg_index` and `tgt_offset` hold until the next address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Active-low cycle framing from the bus |
| idsel | input | 1 | Device select for configuration cycles |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command (address phase) or active-low byte enables (data phase) |
| xfer | input | 1 | A data word moves in this clock (from the handshake logic) |
| bk_irq | input | 1 | Interrupt request from the backend |
| hit | output | 1 | One-clock strobe: device selected |
| cmd_class | output | 3 | Decoded command class of the last address phase |
| cfg_index | output | 6 | Configuration DWORD index |
| tgt_offset | output | 22 | Offset of the access inside its window |
| wr_be | output | 4 | Active-high byte lanes for backend writes |
| cfg_rdata | output | 32 | Configuration read data for `cfg_index` |
| irq_out | output | 1 | Enabled backend interrupt |

## Verification
All sixteen command codes are driven at three kinds of address: one inside the I/O window, one inside the memory window, and a configuration address with the device selected. This separates the per-class selection rule from the command filter. Window edges on both sides of each base register show the compare width, and the space enables are tested while off. Configuration addresses with bad low bits, a non-zero function and junk upper bits test the select rule. A read of all 64 DWORDs, with the expected value computed per index, shows the zero fill and the sizing and byte-lane behaviour of each writable field.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;

   typedef enum logic [2:0] {
      CC_NONE    = 3'd0,
      CC_IO_RD   = 3'd1,
      CC_IO_WR   = 3'd2,
      CC_MEM_RD  = 3'd3,
      CC_MEM_WR  = 3'd4,
      CC_CFG_RD  = 3'd5,
      CC_CFG_WR  = 3'd6
   } cmd_class_e;

   // DWORD indices of implemented header words
   localparam logic [5:0] IDX_IDENT   = 6'h00;
   localparam logic [5:0] IDX_CMD     = 6'h01;
   localparam logic [5:0] IDX_CLASS   = 6'h02;
   localparam logic [5:0] IDX_BAR_IO  = 6'h04;
   localparam logic [5:0] IDX_BAR_MEM = 6'h05;
   localparam logic [5:0] IDX_IRQ     = 6'h12;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

endpackage

// File: rtl/pci_cmd_classify.sv
module pci_cmd_classify
   import pci_dec_pkg::*;
(
   input  logic [3:0]  cmd_code,
   output cmd_class_e  cls
);
   always_comb begin
      unique case (cmd_code)
         4'b0010: cls = CC_IO_RD;
         4'b0011: cls = CC_IO_WR;
         4'b0110: cls = CC_MEM_RD;
         4'b0111: cls = CC_MEM_WR;
         4'b1010: cls = CC_CFG_RD;
         4'b1011: cls = CC_CFG_WR;
         default: cls = CC_NONE;
      endcase
   end
endmodule

// File: rtl/pci_win_match.sv
module pci_win_match #(
   parameter int LO = 8
) (
   input  logic          enable,
   input  logic [31:LO]  addr_hi,
   input  logic [31:LO]  base_hi,
   output logic          match
);
   generate
      if (LO < 1 || LO > 31) begin : g_bad_lo
         $error("pci_win_match: LO out of range");
      end
   endgenerate

   assign match = enable && (addr_hi == base_hi);
endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
   import pci_dec_pkg::*;
#(
   parameter bit          IO_EN     = 1'b1,
   parameter int          IO_AW     = 8,
   parameter int          MEM_AW    = 22,
   parameter logic [31:0] IDENT     = 32'hC0DE_7A11,
   parameter logic [31:0] CLASS_REV = 32'h0B40_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [5:0]        wr_idx,
   input  logic [31:0]       wr_data,
   input  logic [3:0]        wr_be,
   input  logic [5:0]        rd_idx,
   output logic [31:0]       rd_data,
   input  logic              bk_irq,
   output logic              io_en,
   output logic              mem_en,
   output logic [31:IO_AW]   io_base,
   output logic [31:MEM_AW]  mem_base,
   output logic              irq_out
);
   localparam logic [31:0] IO_WMASK  = ~((32'd1 << IO_AW) - 32'd1);
   localparam logic [31:0] MEM_WMASK = ~((32'd1 << MEM_AW) - 32'd1);

   logic [1:0]  cmd_q;
   logic        irq_en_q;
   logic [31:0] mem_bar_q;
   logic [31:0] io_rb;
   logic [31:0] mask;

   assign mask = lane_mask(wr_be);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= 2'b00;
         irq_en_q  <= 1'b0;
         mem_bar_q <= 32'h0;
      end else if (wr_en) begin
         if (wr_idx == IDX_CMD && wr_be[0])
            cmd_q <= wr_data[1:0];
         if (wr_idx == IDX_IRQ && wr_be[0])
            irq_en_q <= wr_data[0];
         if (wr_idx == IDX_BAR_MEM)
            mem_bar_q <= ((mem_bar_q & ~mask) | (wr_data & mask)) & MEM_WMASK;
      end
   end

   generate
      if (IO_EN) begin : g_io
         logic [31:0] io_bar_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               io_bar_q <= 32'h1;
            else if (wr_en && wr_idx == IDX_BAR_IO)
               io_bar_q <= (((io_bar_q & ~mask) | (wr_data & mask)) & IO_WMASK) | 32'h1;
         end
         assign io_rb   = io_bar_q;
         assign io_base = io_bar_q[31:IO_AW];
         assign io_en   = cmd_q[0];
      end else begin : g_no_io
         assign io_rb   = 32'h0;
         assign io_base = '0;
         assign io_en   = 1'b0;
      end
   endgenerate

   assign mem_en   = cmd_q[1];
   assign mem_base = mem_bar_q[31:MEM_AW];
   assign irq_out  = irq_en_q & bk_irq;

   always_comb begin
      unique case (rd_idx)
         IDX_IDENT:   rd_data = IDENT;
         IDX_CMD:     rd_data = {30'h0, cmd_q};
         IDX_CLASS:   rd_data = CLASS_REV;
         IDX_BAR_IO:  rd_data = io_rb;
         IDX_BAR_MEM: rd_data = mem_bar_q;
         IDX_IRQ:     rd_data = {23'h0, bk_irq, 7'h0, irq_en_q};
         default:     rd_data = 32'h0;
      endcase
   end
endmodule

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
   import pci_dec_pkg::*;
#(
   parameter bit          IO_EN     = 1'b1,
   parameter int          IO_AW     = 8,
   parameter int          MEM_AW    = 22,
   parameter logic [31:0] IDENT     = 32'hC0DE_7A11,
   parameter logic [31:0] CLASS_REV = 32'h0B40_0001,
   localparam int         OFF_W     = (MEM_AW > IO_AW) ? MEM_AW : IO_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              idsel,
   input  logic [31:0]       ad,
   input  logic [3:0]        cbe_n,
   input  logic              xfer,
   input  logic              bk_irq,
   output logic              hit,
   output logic [2:0]        cmd_class,
   output logic [5:0]        cfg_index,
   output logic [OFF_W-1:0]  tgt_offset,
   output logic [3:0]        wr_be,
   output logic [31:0]       cfg_rdata,
   output logic              irq_out
);
   generate
      if (IO_AW < 2 || IO_AW > 16) begin : g_bad_io
         $error("pci_tgt_decode: IO_AW must lie in 2..16");
      end
      if (MEM_AW < 8 || MEM_AW > 31) begin : g_bad_mem
         $error("pci_tgt_decode: MEM_AW must lie in 8..31");
      end
   endgenerate

   cmd_class_e           cls_n, cls_q;
   logic                 frame_q, addr_ph;
   logic                 io_en, mem_en, io_match, mem_match, cfg_ok;
   logic                 dec_hit, hit_q, sel_q;
   logic [31:IO_AW]      io_base;
   logic [31:MEM_AW]     mem_base;
   logic [OFF_W-1:0]     off_n, off_q;
   logic [5:0]           idx_q;
   logic                 cfg_wr;

   pci_cmd_classify i_cls (.cmd_code(cbe_n), .cls(cls_n));

   generate
      if (IO_EN) begin : g_io_dec
         pci_win_match #(.LO(IO_AW)) i_io_win (
            .enable(io_en), .addr_hi(ad[31:IO_AW]),
            .base_hi(io_base), .match(io_match));
      end else begin : g_io_off
         assign io_match = 1'b0;
      end
   endgenerate

   pci_win_match #(.LO(MEM_AW)) i_mem_win (
      .enable(mem_en), .addr_hi(ad[31:MEM_AW]),
      .base_hi(mem_base), .match(mem_match));

   assign cfg_ok  = idsel && (ad[1:0] == 2'b00) && (ad[10:8] == 3'b000);
   assign addr_ph = frame_q && !frame_n;

   always_comb begin
      dec_hit = 1'b0;
      off_n   = '0;
      unique case (cls_n)
         CC_IO_RD, CC_IO_WR: begin
            dec_hit = io_match;
            off_n   = OFF_W'(ad[IO_AW-1:0]);
         end
         CC_MEM_RD, CC_MEM_WR: begin
            dec_hit = mem_match;
            off_n   = OFF_W'(ad[MEM_AW-1:0]);
         end
         CC_CFG_RD, CC_CFG_WR: begin
            dec_hit = cfg_ok;
            off_n   = OFF_W'({ad[7:2], 2'b00});
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= 1'b1;
         hit_q   <= 1'b0;
         sel_q   <= 1'b0;
         cls_q   <= CC_NONE;
         idx_q   <= 6'h0;
         off_q   <= '0;
      end else begin
         frame_q <= frame_n;
         hit_q   <= 1'b0;
         if (addr_ph) begin
            hit_q <= dec_hit;
            sel_q <= dec_hit;
            cls_q <= dec_hit ? cls_n : CC_NONE;
            idx_q <= ad[7:2];
            off_q <= off_n;
         end
      end
   end

   assign cfg_wr = xfer && sel_q && (cls_q == CC_CFG_WR);
   assign wr_be  = (xfer && sel_q && (cls_q == CC_IO_WR || cls_q == CC_MEM_WR))
                   ? ~cbe_n : 4'b0000;

   pci_cfg_space #(
      .IO_EN(IO_EN), .IO_AW(IO_AW), .MEM_AW(MEM_AW),
      .IDENT(IDENT), .CLASS_REV(CLASS_REV)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr), .wr_idx(idx_q), .wr_data(ad), .wr_be(~cbe_n),
      .rd_idx(idx_q), .rd_data(cfg_rdata),
      .bk_irq(bk_irq),
      .io_en(io_en), .mem_en(mem_en),
      .io_base(io_base), .mem_base(mem_base),
      .irq_out(irq_out));

   assign hit        = hit_q;
   assign cmd_class  = cls_q;
   assign cfg_index  = idx_q;
   assign tgt_offset = off_q;
endmodule

// File: rtl/pci_dec_chk.sv
module pci_dec_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        frame_n,
   input logic        idsel,
   input logic [4:0]  ad_sel,
   input logic [3:0]  cbe_n,
   input logic        xfer,
   input logic        hit,
   input logic [2:0]  cmd_class,
   input logic [3:0]  wr_be,
   input logic        io_en,
   input logic        mem_en
);
   // R11
   hit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);

   // R11
   hit_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(!frame_n));

   // R1
   cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($past(cbe_n) == 4'b0010 || $past(cbe_n) == 4'b0011 ||
               $past(cbe_n) == 4'b0110 || $past(cbe_n) == 4'b0111 ||
               $past(cbe_n) == 4'b1010 || $past(cbe_n) == 4'b1011));

   // R2
   cfg_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (cmd_class == 3'd5 || cmd_class == 3'd6)) |->
         ($past(idsel) && $past(ad_sel) == 5'b00000));

   // R5
   io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (cmd_class == 3'd1 || cmd_class == 3'd2)) |-> $past(io_en));

   // R5
   mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (cmd_class == 3'd3 || cmd_class == 3'd4)) |-> $past(mem_en));

   // R9
   lane_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_be != 4'b0000) |-> xfer);
endmodule

bind pci_tgt_decode pci_dec_chk u_chk (
   .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .idsel(idsel),
   .ad_sel({ad[10:8], ad[1:0]}), .cbe_n(cbe_n), .xfer(xfer),
   .hit(hit), .cmd_class(cmd_class), .wr_be(wr_be),
   .io_en(io_en), .mem_en(mem_en));

// File: tb/test_pci_tgt_decode.sv
module test_pci_tgt_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic        idsel = 1'b0;
   logic [31:0] ad = 32'h0;
   logic [3:0]  cbe_n = 4'hF;
   logic        xfer = 1'b0;
   logic        bk_irq = 1'b0;
   logic        hit;
   logic [2:0]  cmd_class;
   logic [5:0]  cfg_index;
   logic [21:0] tgt_offset;
   logic [3:0]  wr_be;
   logic [31:0] cfg_rdata;
   logic        irq_out;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   localparam logic [31:0] IDENT     = 32'hC0DE_7A11;
   localparam logic [31:0] CLASS_REV = 32'h0B40_0001;
   localparam logic [31:0] IO_BASE   = 32'h0000_1200;
   localparam logic [31:0] MEM_BASE  = 32'h1240_0000;

   always #10 clk = ~clk;

   pci_tgt_decode i_pci_tgt_decode (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .idsel(idsel), .ad(ad),
      .cbe_n(cbe_n), .xfer(xfer), .bk_irq(bk_irq), .hit(hit),
      .cmd_class(cmd_class), .cfg_index(cfg_index), .tgt_offset(tgt_offset),
      .wr_be(wr_be), .cfg_rdata(cfg_rdata), .irq_out(irq_out));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Address phase: starts at a falling edge, returns at the next falling edge
   task automatic addr(input logic [3:0] cmd, input logic [31:0] a, input logic sel);
      frame_n = 1'b0; cbe_n = cmd; ad = a; idsel = sel;
      @(posedge clk); @(negedge clk);
   endtask

   // Single (last) data phase
   task automatic data(input logic [31:0] d, input logic [3:0] be, input logic x);
      frame_n = 1'b1; idsel = 1'b0; ad = d; cbe_n = ~be; xfer = x;
      @(posedge clk); @(negedge clk);
      xfer = 1'b0; cbe_n = 4'hF;
   endtask

   task automatic cfg_wr(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] be);
      addr(4'b1011, {24'h0, idx, 2'b00}, 1'b1);
      data(d, be, 1'b1);
   endtask

   task automatic cfg_rd(input logic [5:0] idx, output logic [31:0] d);
      addr(4'b1010, {24'h0, idx, 2'b00}, 1'b1);
      d = cfg_rdata;
      data(32'h0, 4'hF, 1'b1);
   endtask

   function automatic logic [2:0] exp_class(input int c);
      case (c)
         2: return 3'd1;  3: return 3'd2;
         6: return 3'd3;  7: return 3'd4;
         10: return 3'd5; 11: return 3'd6;
         default: return 3'd0;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] ex;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk("R11 reset hit", 32'(hit), 32'h0);
      chk("R1 reset class", 32'(cmd_class), 32'h0);
      chk("R10 reset irq_out", 32'(irq_out), 32'h0);
      cfg_rd(6'h01, rd); chk("R5 command word reset", rd, 32'h0);
      cfg_rd(6'h04, rd); chk("R6 io base reset", rd, 32'h1);
      cfg_rd(6'h05, rd); chk("R6 mem base reset", rd, 32'h0);

      // Space enables off: the bases (0) would match these addresses
      addr(4'b0010, 32'h0000_0010, 1'b0);
      chk("R5 io disabled", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);
      addr(4'b0110, 32'h0000_0040, 1'b0);
      chk("R5 mem disabled", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);

      // Sizing
      cfg_wr(6'h04, 32'hFFFF_FFFF, 4'hF);
      cfg_rd(6'h04, rd); chk("R6 io size mask", rd, 32'hFFFF_FF01);
      cfg_wr(6'h05, 32'hFFFF_FFFF, 4'hF);
      cfg_rd(6'h05, rd); chk("R6 mem size mask", rd, 32'hFFC0_0000);

      // Byte-lane writes
      cfg_wr(6'h04, 32'h0000_1200, 4'b0010);
      cfg_rd(6'h04, rd); chk("R8 io lane 1 only", rd, 32'hFFFF_1201);
      cfg_wr(6'h04, 32'h0000_0000, 4'b1100);
      cfg_rd(6'h04, rd); chk("R8 io lanes 3:2", rd, 32'h0000_1201);
      cfg_wr(6'h05, MEM_BASE, 4'hF);
      cfg_rd(6'h05, rd); chk("R4 mem base", rd, MEM_BASE);
      cfg_wr(6'h01, 32'h0000_0003, 4'b0001);
      cfg_wr(6'h01, 32'h0000_0000, 4'b0000);
      cfg_rd(6'h01, rd); chk("R8 no-lane write ignored", rd, 32'h3);

      // Command sweep at three kinds of address
      for (int c = 0; c < 16; c++) begin
         addr(4'(c), IO_BASE | 32'h34, 1'b0);
         chk("R1 io-address hit", 32'(hit), 32'((c == 2) || (c == 3)));
         chk("R1 io-address class", 32'(cmd_class), ((c == 2) || (c == 3)) ? 32'(exp_class(c)) : 32'h0);
         if (c == 2) chk("R3 io offset", 32'(tgt_offset), 32'h34);
         data(0, 4'hF, 1'b0);
         addr(4'(c), MEM_BASE | 32'h0010_0004, 1'b0);
         chk("R1 mem-address hit", 32'(hit), 32'((c == 6) || (c == 7)));
         chk("R1 mem-address class", 32'(cmd_class), ((c == 6) || (c == 7)) ? 32'(exp_class(c)) : 32'h0);
         if (c == 7) chk("R4 mem offset", 32'(tgt_offset), 32'h0010_0004);
         data(0, 4'hF, 1'b0);
         addr(4'(c), 32'h0000_0010, 1'b1);
         chk("R1 cfg-address hit", 32'(hit), 32'((c == 10) || (c == 11)));
         chk("R1 cfg-address class", 32'(cmd_class), ((c == 10) || (c == 11)) ? 32'(exp_class(c)) : 32'h0);
         data(0, 4'hF, 1'b0);
      end

      // I/O window edges, unaligned access and byte lanes
      addr(4'b0010, 32'h0000_12FF, 1'b0);
      chk("R3 io top byte hit", 32'(hit), 32'h1);
      chk("R3 io top offset", 32'(tgt_offset), 32'hFF);
      data(0, 4'hF, 1'b0);
      addr(4'b0010, 32'h0000_1300, 1'b0);
      chk("R3 io above window", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);
      addr(4'b0010, 32'h0000_11FF, 1'b0);
      chk("R3 io below window", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);
      addr(4'b0011, 32'h0000_1235, 1'b0);
      chk("R3 io unaligned hit", 32'(hit), 32'h1);
      chk("R9 no lanes before data", 32'(wr_be), 32'h0);
      frame_n = 1'b1; ad = 32'hA5A5_A5A5; cbe_n = 4'b1010; xfer = 1'b1;
      #1 chk("R9 io write lanes", 32'(wr_be), 32'h5);
      @(posedge clk); @(negedge clk);
      chk("R11 hit gone", 32'(hit), 32'h0);
      chk("R11 class held", 32'(cmd_class), 32'h2);
      chk("R11 offset held", 32'(tgt_offset), 32'h35);
      xfer = 1'b0;
      #1 chk("R9 no lanes without xfer", 32'(wr_be), 32'h0);

      // Memory window edges and lanes
      addr(4'b0111, 32'h127F_FFFC, 1'b0);
      chk("R4 mem top hit", 32'(hit), 32'h1);
      chk("R4 mem top offset", 32'(tgt_offset), 32'h3F_FFFC);
      frame_n = 1'b1; cbe_n = 4'b0011; xfer = 1'b1;
      #1 chk("R9 mem write lanes", 32'(wr_be), 32'hC);
      @(posedge clk); @(negedge clk); xfer = 1'b0; cbe_n = 4'hF;
      addr(4'b0110, 32'h1280_0000, 1'b0);
      chk("R4 mem above window", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);
      addr(4'b0110, 32'h123F_FFFC, 1'b0);
      chk("R4 mem below window", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);
      addr(4'b0110, MEM_BASE, 1'b0);
      frame_n = 1'b1; xfer = 1'b1; cbe_n = 4'b0000;
      #1 chk("R9 read gives no lanes", 32'(wr_be), 32'h0);
      @(posedge clk); @(negedge clk); xfer = 1'b0;

      // Configuration select rule
      addr(4'b1010, 32'hFFFF_F808, 1'b1);
      chk("R2 upper bits ignored", 32'(hit), 32'h1);
      chk("R2 index", 32'(cfg_index), 32'h2);
      chk("R7 class word", cfg_rdata, CLASS_REV);
      data(0, 4'hF, 1'b1);
      addr(4'b1010, 32'h0000_0009, 1'b1);
      chk("R2 low bits 01", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);
      addr(4'b1010, 32'h0000_0100, 1'b1);
      chk("R2 function 1", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);
      addr(4'b1010, 32'h0000_0000, 1'b0);
      chk("R2 idsel low", 32'(hit), 32'h0); data(0, 4'hF, 1'b0);

      // Interrupt word
      cfg_wr(6'h12, 32'h0000_0001, 4'b0001);
      cfg_rd(6'h12, rd); chk("R10 enable only", rd, 32'h1);
      chk("R10 no request", 32'(irq_out), 32'h0);
      bk_irq = 1'b1; #1;
      chk("R10 request passes", 32'(irq_out), 32'h1);
      cfg_rd(6'h12, rd); chk("R10 status bit", rd, 32'h101);
      cfg_wr(6'h12, 32'h0000_0000, 4'b0001);
      chk("R10 disabled", 32'(irq_out), 32'h0);

      // Full header sweep
      for (int i = 0; i < 64; i++) begin
         case (i)
            0:  ex = IDENT;
            1:  ex = 32'h3;
            2:  ex = CLASS_REV;
            4:  ex = IO_BASE | 32'h1;
            5:  ex = MEM_BASE;
            18: ex = 32'h100;
            default: ex = 32'h0;
         endcase
         cfg_rd(6'(i), rd);
         chk("R7 header sweep", rd, ex);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule